// File: doc/BRIEF.md
# Narrow External Bus Master Sequencer

This block sits between a wide on-chip datapath and a 16-bit external bus. A client hands it one request at a time. Each request gives a byte address, an access size (byte, halfword, 32-bit word or 128-bit line), a direction, a space selector, a fetch/operand flag and a flag that marks the target as on-chip. The block breaks the request into halfword beats on the external bus and drives every control line for each beat. It holds each beat for as long as the external slave withholds its completion acknowledge. Read data is gathered into a 128-bit line register.

A 32-bit word takes two beats: the even halfword first, then the odd one. A line takes eight beats. It starts at the halfword that the request points into and wraps around inside its 16-byte block. A request aimed at an on-chip target produces no bus activity, only a completion pulse. The state machine has four states:

- `S_IDLE` takes a request.
- `S_LAUNCH` is the first cycle of a beat and pulses the start strobe.
- `S_HOLD` waits for the acknowledge.
- `S_FINISH` raises the completion pulse.

The transitions are:

- `S_IDLE` to `S_LAUNCH` on an accepted external request.
- `S_IDLE` to `S_FINISH` on an accepted on-chip request.
- `S_LAUNCH` or `S_HOLD` to `S_HOLD` while the acknowledge is high.
- `S_LAUNCH` or `S_HOLD` to `S_LAUNCH` when a beat that is not the last one completes.
- `S_LAUNCH` or `S_HOLD` to `S_FINISH` when the last beat completes.
- `S_FINISH` to `S_IDLE` always.

Top module: `narrow_bus_seq`

## Requirements
- R1: `req_ready` is high only in `S_IDLE`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `rd_line` is cleared to zero on that edge. A `req_valid` raised while busy starts nothing.
- R2: A request with `req_internal`=1 produces no `start_n` pulse and no `seq_n` assertion. `done` goes high in the cycle after acceptance.
- R3: A byte or halfword request (`req_size` 0 or 1) takes one beat. `ext_addr` equals the request address shifted right by one bit, and `seq_n` stays high.
- R4: A word request (`req_size` 2) takes two beats, at halfword addresses `{addr[23:2],0}` and then `{addr[23:2],1}`. `seq_n` is low during both beats.
- R5: A line request (`req_size` 3) takes 8 beats. Beat b uses halfword index (addr[3:1]+b) mod 8 inside the 16-byte block, and `seq_n` is low throughout.
- R6: `start_n` is low for exactly the first cycle of every beat, including each beat of a multi-beat sequence.
- R7: A beat ends only on a clock edge where `ack_n` is low. Until then `start_n` is high and `ext_addr` and the lane strobes hold steady.
- R8: On a read both `lane_hi_n` and `lane_lo_n` are low. On a byte write, only `lane_hi_n` is low for an even address and only `lane_lo_n` is low for an odd address. Halfword, word and line writes drive both low.
- R9: `ext_read` is 1 for a read and 0 for a write. `space_io` is 0 for user space and 1 for I/O space. `access_op` is 0 for a fetch and 1 for an operand access.
- R10: On a write beat at halfword index k, `ext_dout` carries `req_wdata[127-16k -: 16]`.
- R11: On a read, the byte on `ext_din[15:8]` (even byte) and the byte on `ext_din[7:0]` (odd byte) go into `rd_line[127-16k -: 8]` and `rd_line[119-16k -: 8]`. Only the bytes the request names are stored; a byte read keeps only its own byte.
- R12: `done` is a one-cycle pulse in the cycle after the final beat completes, and `req_ready` is high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 user space |
| req_fetch | input | 1 | 1 instruction fetch, 0 operand |
| req_internal | input | 1 | Target is on-chip, no external cycle |
| req_wdata | input | 128 | Write line, halfword 0 in the top bits |
| rd_line | output | 128 | Assembled read line |
| done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 23 | Halfword address |
| ext_dout | output | 16 | Write data |
| ext_din | input | 16 | Read data |
| start_n | output | 1 | Beat start strobe, active low |
| seq_n | output | 1 | Multi-beat sequence indicator, active low |
| lane_hi_n | output | 1 | Even-byte lane strobe (bits 15:8), active low |
| lane_lo_n | output | 1 | Odd-byte lane strobe (bits 7:0), active low |
| ext_read | output | 1 | 1 read, 0 write |
| space_io | output | 1 | Space identifier |
| access_op | output | 1 | 0 fetch, 1 operand |
| ack_n | input | 1 | Slave data-complete acknowledge, active low |

## Verification
Acceptance happens on a clock edge. The first beat's strobes, address and control levels are therefore sampled at the falling edge right after it. For an on-chip request, `done` is sampled at that same falling edge.

Each wait cycle adds exactly one cycle. The bench holds `ack_n` high for a table-given count and checks at every wait's falling edge that `start_n` is high and the address is unchanged. The next beat, or `done` together with the final `rd_line`, is checked at the falling edge after the edge where `ack_n` was low. `req_ready` is checked one cycle after `done`.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    localparam int HW_BITS = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_HOLD   = 2'd2,
        S_FINISH = 2'd3
    } state_e;
endpackage

// File: rtl/nbs_plan.sv
module nbs_plan
    import nbs_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [IDX_W:0]   addr_lo,
    input  size_e            size,
    input  logic             write,
    output logic [CNT_W-1:0] beats,
    output logic [IDX_W-1:0] start_idx,
    output logic             keep_hi,
    output logic             keep_lo,
    output logic             strobe_hi_n,
    output logic             strobe_lo_n
);
    localparam int HW_N = 1 << IDX_W;

    always_comb begin
        beats     = CNT_W'(1);
        start_idx = addr_lo[IDX_W:1];
        keep_hi   = 1'b1;
        keep_lo   = 1'b1;
        unique case (size)
            SZ_BYTE: begin
                keep_hi = ~addr_lo[0];
                keep_lo = addr_lo[0];
            end
            SZ_HALF: begin
                beats = CNT_W'(1);
            end
            SZ_WORD: begin
                beats     = CNT_W'(2);
                start_idx = {addr_lo[IDX_W:2], 1'b0};
            end
            SZ_LINE: begin
                beats = CNT_W'(HW_N);
            end
            default: begin
                beats = CNT_W'(1);
            end
        endcase
        // reads strobe both lanes; writes strobe only the kept bytes
        strobe_hi_n = write ? ~keep_hi : 1'b0;
        strobe_lo_n = write ? ~keep_lo : 1'b0;
    end
endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm
    import nbs_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             internal,
    input  logic [CNT_W-1:0] beats_in,
    input  logic [IDX_W-1:0] start_in,
    input  logic             ack_n,
    output logic             ready,
    output logic             start_n,
    output logic             in_beat,
    output logic             seq_n,
    output logic             capture,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    state_e           state_q, state_d;
    logic [CNT_W-1:0] beats_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_beat;
    logic             beat_end;

    assign last_beat = (cnt_q == beats_q - CNT_W'(1));
    assign beat_end  = ((state_q == S_LAUNCH) || (state_q == S_HOLD)) && !ack_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = internal ? S_FINISH : S_LAUNCH;
            end
            S_LAUNCH, S_HOLD: begin
                if (!ack_n) state_d = last_beat ? S_FINISH : S_LAUNCH;
                else        state_d = S_HOLD;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and beat bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beats_q <= CNT_W'(1);
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                beats_q <= beats_in;
                cnt_q   <= '0;
                idx_q   <= start_in;
            end else if (beat_end && !last_beat) begin
                cnt_q <= cnt_q + CNT_W'(1);
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        ready   = 1'b0;
        start_n = 1'b1;
        in_beat = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            S_IDLE:   ready = 1'b1;
            S_LAUNCH: begin
                start_n = 1'b0;
                in_beat = 1'b1;
            end
            S_HOLD:   in_beat = 1'b1;
            S_FINISH: done = 1'b1;
            default:  ready = 1'b0;
        endcase
        seq_n   = !(in_beat && (beats_q > CNT_W'(1)));
        capture = beat_end;
        idx     = idx_q;
    end
endmodule

// File: rtl/nbs_linebuf.sv
module nbs_linebuf
    import nbs_pkg::*;
#(
    parameter int LINE_W = 128,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic [IDX_W-1:0]    idx,
    input  logic                keep_hi,
    input  logic                keep_lo,
    input  logic [HW_BITS-1:0]  din,
    input  logic [LINE_W-1:0]   wdata,
    output logic [LINE_W-1:0]   line,
    output logic [HW_BITS-1:0]  dout
);
    localparam int HW_N = LINE_W / HW_BITS;

    logic [HW_BITS-1:0] wr_slot [HW_N];

    for (genvar k = 0; k < HW_N; k++) begin : g_slot
        localparam int TOP = LINE_W - 1 - HW_BITS * k;
        logic [HW_BITS-1:0] slot_q;
        logic               hit;

        assign hit = capture && (idx == IDX_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (clear) begin
                slot_q <= '0;
            end else if (hit) begin
                if (keep_hi) slot_q[15:8] <= din[15:8];
                if (keep_lo) slot_q[7:0]  <= din[7:0];
            end
        end

        assign line[TOP -: HW_BITS] = slot_q;
        assign wr_slot[k]           = wdata[TOP -: HW_BITS];
    end

    assign dout = wr_slot[idx];
endmodule

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq
    import nbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_fetch,
    input  logic              req_internal,
    input  logic [LINE_W-1:0] req_wdata,
    output logic [LINE_W-1:0] rd_line,
    output logic              done,
    output logic [ADDR_W-2:0] ext_addr,
    output logic [15:0]       ext_dout,
    input  logic [15:0]       ext_din,
    output logic              start_n,
    output logic              seq_n,
    output logic              lane_hi_n,
    output logic              lane_lo_n,
    output logic              ext_read,
    output logic              space_io,
    output logic              access_op,
    input  logic              ack_n
);
    localparam int HW_N  = LINE_W / HW_BITS;
    localparam int IDX_W = $clog2(HW_N);
    localparam int CNT_W = $clog2(HW_N + 1);
    localparam int BLK_W = ADDR_W - 1 - IDX_W;

    logic             accept;
    logic [CNT_W-1:0] plan_beats;
    logic [IDX_W-1:0] plan_start;
    logic             plan_keep_hi, plan_keep_lo;
    logic             plan_str_hi_n, plan_str_lo_n;

    logic [BLK_W-1:0]  blk_q;
    logic              write_q, io_q, fetch_q;
    logic              keep_hi_q, keep_lo_q;
    logic              str_hi_q, str_lo_q;
    logic [LINE_W-1:0] wdata_q;

    logic             in_beat, capture;
    logic [IDX_W-1:0] idx;
    logic [15:0]      wr_half;

    assign accept = req_valid && req_ready;

    nbs_plan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) plan_i (
        .addr_lo     (req_addr[IDX_W:0]),
        .size        (size_e'(req_size)),
        .write       (req_write),
        .beats       (plan_beats),
        .start_idx   (plan_start),
        .keep_hi     (plan_keep_hi),
        .keep_lo     (plan_keep_lo),
        .strobe_hi_n (plan_str_hi_n),
        .strobe_lo_n (plan_str_lo_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q     <= '0;
            write_q   <= 1'b0;
            io_q      <= 1'b0;
            fetch_q   <= 1'b0;
            keep_hi_q <= 1'b0;
            keep_lo_q <= 1'b0;
            str_hi_q  <= 1'b1;
            str_lo_q  <= 1'b1;
            wdata_q   <= '0;
        end else if (accept) begin
            blk_q     <= req_addr[ADDR_W-1:IDX_W+1];
            write_q   <= req_write;
            io_q      <= req_io;
            fetch_q   <= req_fetch;
            keep_hi_q <= plan_keep_hi;
            keep_lo_q <= plan_keep_lo;
            str_hi_q  <= plan_str_hi_n;
            str_lo_q  <= plan_str_lo_n;
            wdata_q   <= req_wdata;
        end
    end

    nbs_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .internal (req_internal),
        .beats_in (plan_beats),
        .start_in (plan_start),
        .ack_n    (ack_n),
        .ready    (req_ready),
        .start_n  (start_n),
        .in_beat  (in_beat),
        .seq_n    (seq_n),
        .capture  (capture),
        .done     (done),
        .idx      (idx)
    );

    nbs_linebuf #(.LINE_W(LINE_W), .IDX_W(IDX_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture && !write_q),
        .idx     (idx),
        .keep_hi (keep_hi_q),
        .keep_lo (keep_lo_q),
        .din     (ext_din),
        .wdata   (wdata_q),
        .line    (rd_line),
        .dout    (wr_half)
    );

    always_comb begin
        ext_addr  = in_beat ? {blk_q, idx} : '0;
        ext_dout  = (in_beat && write_q) ? wr_half : '0;
        lane_hi_n = in_beat ? str_hi_q : 1'b1;
        lane_lo_n = in_beat ? str_lo_q : 1'b1;
        ext_read  = in_beat ? !write_q : 1'b1;
        space_io  = in_beat && io_q;
        access_op = in_beat ? !fetch_q : 1'b1;
    end
endmodule

// File: rtl/nbs_chk.sv
module nbs_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              start_n,
    input logic              seq_n,
    input logic              lane_hi_n,
    input logic              lane_lo_n,
    input logic              ext_read,
    input logic              ack_n,
    input logic [ADDR_W-2:0] ext_addr
);
    logic beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= 1'b0;
        else        beat_q <= (!start_n || beat_q) && ack_n;
    end

    // R1
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n || beat_q) |-> !req_ready);

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!start_n || beat_q) && ack_n) |=> (start_n && $stable(ext_addr)
                                              && $stable(lane_hi_n) && $stable(lane_lo_n)));

    // R4
    seq_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_n |-> (!start_n || beat_q));

    // R8
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n && ext_read) |-> (!lane_hi_n && !lane_lo_n));

    // R8
    some_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |-> !(lane_hi_n && lane_lo_n));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (start_n && seq_n));
endmodule

bind narrow_bus_seq nbs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .start_n   (start_n),
    .seq_n     (seq_n),
    .lane_hi_n (lane_hi_n),
    .lane_lo_n (lane_lo_n),
    .ext_read  (ext_read),
    .ack_n     (ack_n),
    .ext_addr  (ext_addr)
);

// File: tb/narrow_bus_seq_tb.sv
`timescale 1ns/1ps
module narrow_bus_seq_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [23:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         req_write = 1'b0;
    logic         req_io = 1'b0;
    logic         req_fetch = 1'b0;
    logic         req_internal = 1'b0;
    logic [127:0] req_wdata = '0;
    logic [127:0] rd_line;
    logic         done;
    logic [22:0]  ext_addr;
    logic [15:0]  ext_dout;
    logic [15:0]  ext_din;
    logic         start_n, seq_n, lane_hi_n, lane_lo_n;
    logic         ext_read, space_io, access_op;
    logic         ack_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign ext_din = ext_addr[15:0] ^ 16'h5A3C;

    narrow_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_io(req_io), .req_fetch(req_fetch), .req_internal(req_internal),
        .req_wdata(req_wdata), .rd_line(rd_line), .done(done),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .start_n(start_n), .seq_n(seq_n), .lane_hi_n(lane_hi_n),
        .lane_lo_n(lane_lo_n), .ext_read(ext_read), .space_io(space_io),
        .access_op(access_op), .ack_n(ack_n)
    );

    typedef struct packed {
        logic [23:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic        io;
        logic        fetch;
        logic        intl;
        logic [1:0]  waits;
        logic [3:0]  beats;
        logic [2:0]  idx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{24'h001234, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1, 3'd2},
        '{24'h000101, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1, 3'd0},
        '{24'h000100, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1, 3'd0},
        '{24'h000208, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 4'd2, 3'd4},
        '{24'h00030C, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2, 3'd6},
        '{24'h00040E, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd8, 3'd7},
        '{24'h000500, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd8, 3'd0},
        '{24'h000010, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0, 3'd0},
        '{24'h00FFFE, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4'd1, 3'd7},
        '{24'h000207, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd1, 3'd3}
    };

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit crowd);
        logic [127:0] exp_line = '0;
        string        atag;
        bit           keep_hi, keep_lo;
        atag    = (v.size == 2'd3) ? "R5 line addr" : (v.size == 2'd2) ? "R4 word addr" : "R3 single addr";
        keep_hi = !(v.size == 2'd0 && v.addr[0]);
        keep_lo = !(v.size == 2'd0 && !v.addr[0]);
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready when idle", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_write = v.wr;
        req_io = v.io; req_fetch = v.fetch; req_internal = v.intl;
        @(posedge clk);
        @(negedge clk);
        if (crowd) begin
            req_addr = 24'h00ABCD; req_size = 2'd3; req_internal = 1'b0;
        end else begin
            req_valid = 1'b0;
        end
        if (v.intl) begin
            chk(done === 1'b1, "R2 done after internal", 128'(done), 128'd1);
            chk(start_n === 1'b1 && seq_n === 1'b1, "R2 no bus cycle",
                128'({start_n, seq_n}), 128'd3);
        end else begin
            for (int b = 0; b < int'(v.beats); b++) begin
                logic [2:0]  ix;
                logic [22:0] ha;
                logic [15:0] dv;
                logic [22:0] held;
                ix = v.idx + 3'(b);
                ha = {v.addr[23:4], ix};
                dv = ha[15:0] ^ 16'h5A3C;
                chk(start_n === 1'b0, "R6 start strobe on beat", 128'(start_n), 128'd0);
                chk(ext_addr === ha, atag, 128'(ext_addr), 128'(ha));
                chk(seq_n === (v.beats == 4'd1), "R4 sequence indicator",
                    128'(seq_n), 128'(v.beats == 4'd1));
                chk(lane_hi_n === (v.wr && !keep_hi) && lane_lo_n === (v.wr && !keep_lo),
                    "R8 lane strobes", 128'({lane_hi_n, lane_lo_n}),
                    128'({v.wr && !keep_hi, v.wr && !keep_lo}));
                chk(ext_read === !v.wr && space_io === v.io && access_op === !v.fetch,
                    "R9 control levels", 128'({ext_read, space_io, access_op}),
                    128'({!v.wr, v.io, !v.fetch}));
                chk(req_ready === 1'b0, "R1 ready low while busy", 128'(req_ready), 128'd0);
                if (v.wr)
                    chk(ext_dout === req_wdata[127-16*int'(ix) -: 16], "R10 write data",
                        128'(ext_dout), 128'(req_wdata[127-16*int'(ix) -: 16]));
                held = ext_addr;
                ack_n = 1'b1;
                for (int w = 0; w < int'(v.waits); w++) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk(start_n === 1'b1 && ext_addr === held && done === 1'b0,
                        "R7 wait holds beat", 128'({start_n, ext_addr, done}),
                        128'({1'b1, held, 1'b0}));
                end
                ack_n = 1'b0;
                if (!v.wr) begin
                    if (keep_hi) exp_line[127-16*int'(ix) -: 8] = dv[15:8];
                    if (keep_lo) exp_line[119-16*int'(ix) -: 8] = dv[7:0];
                end
                @(posedge clk);
                @(negedge clk);
                ack_n = 1'b1;
                if (b == int'(v.beats) - 1) req_valid = 1'b0;
            end
            chk(done === 1'b1, "R12 done after last beat", 128'(done), 128'd1);
        end
        chk(rd_line === exp_line, "R11 read line merge", rd_line, exp_line);
        @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0, "R12 ready after done",
            128'({req_ready, done}), 128'd2);
        chk(start_n === 1'b1, "R1 no cycle from held-off request", 128'(start_n), 128'd1);
    endtask

    initial begin
        for (int k = 0; k < 8; k++)
            req_wdata[127-16*k -: 16] = 16'hC000 + 16'(k) * 16'h0111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && done === 1'b0, "R1 reset ready/done",
            128'({req_ready, done}), 128'd2);
        chk(start_n === 1'b1 && seq_n === 1'b1, "R6 reset strobes idle",
            128'({start_n, seq_n}), 128'd3);
        chk(lane_hi_n === 1'b1 && lane_lo_n === 1'b1, "R8 reset lanes idle",
            128'({lane_hi_n, lane_lo_n}), 128'd3);
        chk(rd_line === '0, "R11 reset line", rd_line, 128'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

        // R1: a request held up while busy must not start a second sequence
        run_vec('{24'h000604, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd2, 3'd2}, 1'b1);
        // R5: line wrap from the last halfword with writes, waits on every beat
        run_vec('{24'h00071E, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'd8, 3'd7}, 1'b0);
        // R11: a previous line is cleared by the next accepted read
        run_vec('{24'h000801, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd1, 3'd0}, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule